// File: doc/BRIEF.md
# Dual-Space I2C Slave Controller

This block is an I2C target that serves two separate address spaces from one bus connection. One space is a 512-byte data array. The other is a smaller bank of clock and control registers. A fast system clock oversamples SCL and SDA. The block finds start and stop conditions in those samples and assembles bytes from the bit stream.

The upper nibble of the slave byte selects the space. A two-byte word address then loads a shared address counter. The block supports writes, current-address reads, random reads (a dummy write followed by a repeated start) and sequential reads. On the bus it only ever pulls SDA low, through an open-drain enable. Storage sits outside the block, behind a simple port: a space select, an address, write data, a one-cycle write strobe, and read data that follows the address with no added delay.

A random read must name the same space in its dummy-write slave byte and in its read slave byte. If the two differ, the read slave byte is not acknowledged.

Top module: `dual_space_i2c_slave`

## Requirements
- R1: A slave byte is acknowledged only when its bits 7:1 equal 1010111 or 1101111. Bit 0 selects the direction: 1 means read and 0 means write. After a non-acknowledged slave byte, SDA stays released and the block ignores the bus until the next start.
- R2: A slave byte with upper nibble 1010 sets mem_space to 0 (the data array). Upper nibble 1101 sets mem_space to 1 (the register bank).
- R3: A write goes as follows. The slave byte comes first. The first address byte follows, and only its bit 0 is used, as A8. The second address byte carries A7..A0. Every data byte after that produces one mem_we pulse, one clock cycle long, carrying that byte and the current address. The block acknowledges every one of these bytes.
- R4: The address counter advances by one after each data byte that is written or transmitted. In the array it wraps from 511 to 0. In the register bank it wraps from REG_DEPTH-1 (default 63) to 0. The counter is shared between the spaces and is masked to the depth of the selected space both when it is loaded and when it is used.
- R5: The address counter is 0 after reset. A current-address read (a read slave byte with no word address before it) starts at the counter's value.
- R6: Read data is sent MSB first, one bit per SCL clock. The block releases SDA for the ninth clock.
- R7: If the master acknowledges, the block sends the byte at the advanced address. If the master does not acknowledge, the block drives nothing more until a start or stop.
- R8: A stop condition returns the block to idle from any point, including the middle of a byte. Bytes clocked after a stop and without a start are not acknowledged and cause no write.
- R9: Within one transaction, after an acknowledged write slave byte, a read slave byte for the other space is not acknowledged.
- R10: A repeated start at any byte boundary restarts slave-byte reception without a stop. Writes already made are kept, and the counter continues from where it was.
- R11: SDA is only ever pulled low, through sda_oe. sda_oe changes only while SCL is low.
- R12: During and right after reset, sda_oe and mem_we are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | When 1, pulls SDA low |
| mem_space | output | 1 | 0 selects the data array, 1 selects the register bank |
| mem_addr | output | 9 | Address within the selected space |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | One-cycle write strobe |
| mem_rdata | input | 8 | Byte at mem_space/mem_addr, combinational |

## Verification
The hardest cases to reach from the pins are the ones where the bus leaves a transfer at an unusual point. One is a stop that arrives halfway through a data byte. Another is a repeated start that switches space between the dummy write and the read. The bench's bit-level master can cut a byte short with a stop after any number of bits, then clock a whole byte with no start to confirm that nothing is acknowledged or written. It can also build a dummy write to one space followed by a read slave byte for the other. Random write/read-back rounds with a fixed seed cover address wrap in both spaces, including register-bank addresses above the bank depth, and current-address reads that cross between spaces.

// File: rtl/i2c_dual_pkg.sv
package i2c_dual_pkg;

    localparam logic [3:0] NIB_ARRAY = 4'b1010;
    localparam logic [3:0] NIB_REGS  = 4'b1101;
    localparam logic [2:0] SEL_BITS  = 3'b111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_WAIT
    } bus_state_e;

    typedef enum logic [1:0] {
        PH_SLAVE,
        PH_ADDR_HI,
        PH_ADDR_LO,
        PH_DATA
    } rx_phase_e;

    typedef enum logic {
        SP_ARRAY = 1'b0,
        SP_REGS  = 1'b1
    } space_e;

    typedef struct packed {
        logic   hit;
        space_e space;
        logic   rd;
    } slave_dec_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    function automatic slave_dec_t decode_slave(input logic [7:0] b);
        slave_dec_t d;
        d.rd    = b[0];
        d.space = (b[7:4] == NIB_REGS) ? SP_REGS : SP_ARRAY;
        d.hit   = (b[3:1] == SEL_BITS) &&
                  ((b[7:4] == NIB_ARRAY) || (b[7:4] == NIB_REGS));
        return d;
    endfunction

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler
    import i2c_dual_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output line_ev_t ev
);

    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   scl_q;
    logic                   sda_q;
    logic                   scl_s;
    logic                   sda_s;

    assign scl_s = scl_sync[SYNC_STAGES-1];
    assign sda_s = sda_sync[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_in};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    always_comb begin
        ev.scl      = scl_s;
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        // SDA edges with SCL held high are bus conditions, not data
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/i2c_addr_counter.sv
module i2c_addr_counter
    import i2c_dual_pkg::*;
#(
    parameter int ARRAY_DEPTH = 512,
    parameter int REG_DEPTH   = 64,
    parameter int AW          = $clog2(ARRAY_DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  space_e        space,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          incr,
    output logic [AW-1:0] addr
);

    localparam logic [AW-1:0] ARR_LAST = AW'(ARRAY_DEPTH - 1);
    localparam logic [AW-1:0] REG_LAST = AW'(REG_DEPTH - 1);

    logic [AW-1:0] cnt_q;
    logic [AW-1:0] last;
    logic [AW-1:0] masked;

    assign last   = (space == SP_REGS) ? REG_LAST : ARR_LAST;
    assign masked = cnt_q & last;
    assign addr   = masked;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val & last;
        end else if (incr) begin
            cnt_q <= (masked == last) ? '0 : masked + AW'(1);
        end
    end

endmodule

// File: rtl/dual_space_i2c_slave.sv
module dual_space_i2c_slave
    import i2c_dual_pkg::*;
#(
    parameter int ARRAY_DEPTH = 512,
    parameter int REG_DEPTH   = 64,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = $clog2(ARRAY_DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    output logic          mem_space,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          mem_we,
    input  logic [7:0]    mem_rdata
);

    line_ev_t      ev;
    bus_state_e    state;
    rx_phase_e     phase;
    logic [3:0]    bit_cnt;
    logic [6:0]    rx_sh;
    logic [7:0]    tx_sh;
    logic [7:0]    rx_byte;
    slave_dec_t    dec;
    logic          ack_ok;
    logic          go_tx;
    logic          mack_ok;
    logic          a8;
    space_e        space_q;
    logic          dw_valid;
    space_e        dw_space;
    logic          ld;
    logic [AW-1:0] ld_val;
    logic          rd_incr;

    i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_i),
        .sda_in (sda_i),
        .ev     (ev)
    );

    i2c_addr_counter #(
        .ARRAY_DEPTH (ARRAY_DEPTH),
        .REG_DEPTH   (REG_DEPTH),
        .AW          (AW)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .space    (space_q),
        .load     (ld),
        .load_val (ld_val),
        .incr     (mem_we | rd_incr),
        .addr     (mem_addr)
    );

    assign rx_byte   = {rx_sh, ev.sda};
    assign dec       = decode_slave(rx_byte);
    assign mem_space = (space_q == SP_REGS);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            phase     <= PH_SLAVE;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            ack_ok    <= 1'b0;
            go_tx     <= 1'b0;
            mack_ok   <= 1'b0;
            a8        <= 1'b0;
            space_q   <= SP_ARRAY;
            dw_valid  <= 1'b0;
            dw_space  <= SP_ARRAY;
            sda_oe    <= 1'b0;
            mem_we    <= 1'b0;
            mem_wdata <= '0;
            ld        <= 1'b0;
            ld_val    <= '0;
            rd_incr   <= 1'b0;
        end else begin
            mem_we  <= 1'b0;
            ld      <= 1'b0;
            rd_incr <= 1'b0;
            if (ev.stop) begin
                state    <= ST_IDLE;
                sda_oe   <= 1'b0;
                dw_valid <= 1'b0;
            end else if (ev.start) begin
                state   <= ST_RX;
                phase   <= PH_SLAVE;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE, ST_WAIT: ;
                    ST_RX: begin
                        if (ev.scl_rise) begin
                            rx_sh   <= rx_byte[6:0];
                            bit_cnt <= bit_cnt + 4'd1;
                            if (bit_cnt == 4'd7) begin
                                go_tx <= 1'b0;
                                unique case (phase)
                                    PH_SLAVE: begin
                                        if (dec.hit && !(dec.rd && dw_valid && (dec.space != dw_space))) begin
                                            ack_ok  <= 1'b1;
                                            space_q <= dec.space;
                                            go_tx   <= dec.rd;
                                            phase   <= PH_ADDR_HI;
                                            if (!dec.rd) begin
                                                dw_valid <= 1'b1;
                                                dw_space <= dec.space;
                                            end
                                        end else begin
                                            ack_ok <= 1'b0;
                                        end
                                    end
                                    PH_ADDR_HI: begin
                                        a8     <= rx_byte[0];
                                        ack_ok <= 1'b1;
                                        phase  <= PH_ADDR_LO;
                                    end
                                    PH_ADDR_LO: begin
                                        ld     <= 1'b1;
                                        ld_val <= AW'({a8, rx_byte});
                                        ack_ok <= 1'b1;
                                        phase  <= PH_DATA;
                                    end
                                    PH_DATA: begin
                                        mem_we    <= 1'b1;
                                        mem_wdata <= rx_byte;
                                        ack_ok    <= 1'b1;
                                    end
                                endcase
                            end
                        end else if (ev.scl_fall && bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            if (ack_ok) begin
                                state  <= ST_ACK;
                                sda_oe <= 1'b1;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (ev.scl_rise) begin
                            bit_cnt <= 4'd1;
                        end else if (ev.scl_fall && bit_cnt == 4'd1) begin
                            bit_cnt <= '0;
                            if (go_tx) begin
                                state  <= ST_TX;
                                sda_oe <= ~mem_rdata[7];
                                tx_sh  <= {mem_rdata[6:0], 1'b0};
                            end else begin
                                state  <= ST_RX;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev.scl_rise) begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (ev.scl_fall) begin
                            if (bit_cnt == 4'd8) begin
                                sda_oe  <= 1'b0;
                                bit_cnt <= '0;
                                state   <= ST_MACK;
                            end else begin
                                sda_oe <= ~tx_sh[7];
                                tx_sh  <= {tx_sh[6:0], 1'b0};
                            end
                        end
                    end
                    ST_MACK: begin
                        if (ev.scl_rise) begin
                            bit_cnt <= 4'd1;
                            rd_incr <= 1'b1;
                            mack_ok <= ~ev.sda;
                        end else if (ev.scl_fall && bit_cnt == 4'd1) begin
                            bit_cnt <= '0;
                            if (mack_ok) begin
                                state  <= ST_TX;
                                sda_oe <= ~mem_rdata[7];
                                tx_sh  <= {mem_rdata[6:0], 1'b0};
                            end else begin
                                state <= ST_WAIT;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/dual_space_i2c_checker.sv
module dual_space_i2c_checker
    import i2c_dual_pkg::*;
#(
    parameter int REG_DEPTH = 64,
    parameter int AW        = 9
) (
    input logic          clk,
    input logic          rst,
    input logic          sda_oe,
    input logic          mem_we,
    input logic          mem_space,
    input logic [AW-1:0] mem_addr,
    input logic          scl_s,
    input logic          stop_seen,
    input bus_state_e    state
);

    a_r11_oe_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_s);

    a_r3_we_single_cycle: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    a_r4_reg_addr_in_bank: assert property (@(posedge clk) disable iff (rst)
        mem_space |-> (32'(mem_addr) < REG_DEPTH));

    a_r8_stop_to_idle: assert property (@(posedge clk) disable iff (rst)
        stop_seen |=> (state == ST_IDLE && !sda_oe));

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (!sda_oe && !mem_we));

endmodule

bind dual_space_i2c_slave dual_space_i2c_checker #(
    .REG_DEPTH (REG_DEPTH),
    .AW        (AW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sda_oe    (sda_oe),
    .mem_we    (mem_we),
    .mem_space (mem_space),
    .mem_addr  (mem_addr),
    .scl_s     (ev.scl),
    .stop_seen (ev.stop),
    .state     (state)
);

// File: tb/test_dual_space_i2c_slave.sv
module test_dual_space_i2c_slave;

    localparam int Q = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic       mem_space;
    logic [8:0] mem_addr;
    logic [7:0] mem_wdata;
    logic       mem_we;
    logic [7:0] mem_rdata;
    logic       sda_line;

    logic [7:0] mem_arr [512];
    logic [7:0] mem_reg [64];
    logic [7:0] exp_arr [512];
    logic [7:0] exp_reg [64];
    logic [7:0] wbuf [8];
    logic [8:0] exp_cnt;
    int         we_count = 0;
    logic       last_we_space = 1'b0;
    int         n_chk = 0;
    int         n_fail = 0;
    int         oe_viol = 0;
    logic       prev_oe = 1'b0;
    logic       mon_on = 1'b0;

    // 125 MHz system clock, 8 ns period
    always #4 clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign mem_rdata = mem_space ? mem_reg[mem_addr[5:0]] : mem_arr[mem_addr];

    dual_space_i2c_slave i_dual_space_i2c_slave (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .mem_space (mem_space),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata)
    );

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 512; i++) mem_arr[i] <= 8'(i * 37 + 11);
            for (int i = 0; i < 64; i++)  mem_reg[i] <= 8'(i * 5 + 200);
        end else if (mem_we) begin
            if (mem_space) mem_reg[mem_addr[5:0]] <= mem_wdata;
            else           mem_arr[mem_addr]      <= mem_wdata;
            we_count      <= we_count + 1;
            last_we_space <= mem_space;
        end
    end

    // R11: no change of the pull-down while the bus clock is high
    always @(negedge clk) begin
        prev_oe <= sda_oe;
        if (mon_on && scl_m && (sda_oe !== prev_oe)) oe_viol <= oe_viol + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    function automatic logic [8:0] mask_of(input logic sp);
        return sp ? 9'd63 : 9'd511;
    endfunction

    function automatic logic [8:0] adv(input logic sp, input logic [8:0] a);
        logic [8:0] m;
        m = a & mask_of(sp);
        return (m == mask_of(sp)) ? 9'd0 : m + 9'd1;
    endfunction

    function automatic logic [7:0] exp_at(input logic sp, input logic [8:0] a);
        return sp ? exp_reg[a[5:0]] : exp_arr[a];
    endfunction

    function automatic logic [7:0] slave_byte(input logic sp, input logic rd);
        return {(sp ? 4'b1101 : 4'b1010), 3'b111, rd};
    endfunction

    task automatic q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; q();
        scl_m = 1'b1; q();
        sda_m = 1'b0; q();
        scl_m = 1'b0; q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; q();
        scl_m = 1'b1; q();
        sda_m = 1'b1; q(); q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; q();
            scl_m = 1'b1; q(); q();
            scl_m = 1'b0; q();
        end
        sda_m = 1'b1; q();
        scl_m = 1'b1; q();
        ack = ~sda_line; q();
        scl_m = 1'b0; q();
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            q();
            scl_m = 1'b1; q();
            b = {b[6:0], sda_line}; q();
            scl_m = 1'b0; q();
        end
        sda_m = ~mack; q();
        scl_m = 1'b1; q(); q();
        scl_m = 1'b0; q();
        sda_m = 1'b1;
    endtask

    task automatic write_txn(input logic sp, input logic [8:0] a, input int len, input logic [6:0] junk);
        logic       ack;
        logic [8:0] p;
        int         wc0;
        wc0 = we_count;
        bus_start();
        send_byte(slave_byte(sp, 1'b0), ack);
        check("R1 write slave byte ack", 32'(ack), 1);
        send_byte({junk, a[8]}, ack);
        check("R3 high address byte ack", 32'(ack), 1);
        send_byte(a[7:0], ack);
        check("R3 low address byte ack", 32'(ack), 1);
        p = a & mask_of(sp);
        for (int i = 0; i < len; i++) begin
            send_byte(wbuf[i], ack);
            check("R3 data byte ack", 32'(ack), 1);
            if (sp) exp_reg[p[5:0]] = wbuf[i];
            else    exp_arr[p]      = wbuf[i];
            p = adv(sp, p);
        end
        bus_stop();
        exp_cnt = p;
        check("R3 one strobe per data byte", 32'(we_count - wc0), 32'(len));
        check("R2 space of last write", 32'(last_we_space), 32'(sp));
    endtask

    task automatic read_random(input logic sp, input logic [8:0] a, input int len);
        logic       ack;
        logic [7:0] b;
        logic [8:0] p;
        bus_start();
        send_byte(slave_byte(sp, 1'b0), ack);
        check("R1 dummy write slave ack", 32'(ack), 1);
        send_byte({7'd0, a[8]}, ack);
        send_byte(a[7:0], ack);
        bus_start();
        send_byte(slave_byte(sp, 1'b1), ack);
        check("R10 read slave byte after repeated start ack", 32'(ack), 1);
        p = a & mask_of(sp);
        for (int i = 0; i < len; i++) begin
            recv_byte(i != len - 1, b);
            check("R6 R7 R4 random read data", 32'(b), 32'(exp_at(sp, p)));
            p = adv(sp, p);
        end
        bus_stop();
        exp_cnt = p;
    endtask

    task automatic read_current(input logic sp, input int len);
        logic       ack;
        logic [7:0] b;
        logic [8:0] p;
        bus_start();
        send_byte(slave_byte(sp, 1'b1), ack);
        check("R1 read slave byte ack", 32'(ack), 1);
        p = exp_cnt & mask_of(sp);
        for (int i = 0; i < len; i++) begin
            recv_byte(i != len - 1, b);
            check("R5 R4 current-address read data", 32'(b), 32'(exp_at(sp, p)));
            p = adv(sp, p);
        end
        bus_stop();
        exp_cnt = p;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic       ack;
        logic [7:0] b;
        int         wc0;
        logic       sp;
        logic [8:0] a;
        int         len;

        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 512; i++) exp_arr[i] = 8'(i * 37 + 11);
        for (int i = 0; i < 64; i++)  exp_reg[i] = 8'(i * 5 + 200);
        exp_cnt = 9'd0;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R12 sda_oe after reset", 32'(sda_oe), 0);
        check("R12 mem_we after reset", 32'(mem_we), 0);
        check("R5 counter after reset", 32'(mem_addr), 0);
        mon_on = 1'b1;

        // R5: current-address read straight after reset starts at 0
        read_current(1'b0, 1);

        // R1: wrong select bits and wrong identifier nibble are refused
        bus_start();
        send_byte(8'b1010_110_1, ack);
        check("R1 wrong select bits nack", 32'(ack), 0);
        bus_stop();
        bus_start();
        send_byte(8'b1011_111_0, ack);
        check("R1 wrong identifier nack", 32'(ack), 0);
        bus_stop();

        // R3/R4: array write at the top with junk high-address bits, wraps to 0
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
        write_txn(1'b0, 9'h1FE, 3, 7'h79);
        read_random(1'b0, 9'h1FE, 3);

        // R2/R4: register bank wraps at 63
        wbuf[0] = 8'h3C; wbuf[1] = 8'h4D;
        write_txn(1'b1, 9'h03F, 2, 7'h00);
        read_random(1'b1, 9'h03F, 2);

        // R9: dummy write to the array, read slave byte for the registers
        bus_start();
        send_byte(slave_byte(1'b0, 1'b0), ack);
        send_byte(8'h00, ack);
        send_byte(8'h05, ack);
        bus_start();
        send_byte(slave_byte(1'b1, 1'b1), ack);
        check("R9 mismatched space refused", 32'(ack), 0);
        bus_stop();
        exp_cnt = 9'h005;
        bus_start();
        send_byte(slave_byte(1'b1, 1'b0), ack);
        send_byte(8'h00, ack);
        send_byte(8'h07, ack);
        bus_start();
        send_byte(slave_byte(1'b0, 1'b1), ack);
        check("R9 mismatched space refused (reverse)", 32'(ack), 0);
        bus_stop();
        exp_cnt = 9'h007;

        // R8: stop in the middle of a data byte, then a byte with no start
        wc0 = we_count;
        bus_start();
        send_byte(slave_byte(1'b0, 1'b0), ack);
        send_byte(8'h00, ack);
        send_byte(8'h10, ack);
        for (int i = 0; i < 4; i++) begin
            sda_m = i[0]; q();
            scl_m = 1'b1; q(); q();
            scl_m = 1'b0; q();
        end
        bus_stop();
        send_byte(8'h77, ack);
        check("R8 byte after stop without start nack", 32'(ack), 0);
        check("R8 no write after stop", 32'(we_count - wc0), 0);
        read_random(1'b0, 9'h010, 1);

        // R7: master nack ends the transfer; further clocks read all ones
        bus_start();
        send_byte(slave_byte(1'b0, 1'b1), ack);
        recv_byte(1'b0, b);
        check("R7 byte before nack", 32'(b), 32'(exp_at(1'b0, exp_cnt & 9'd511)));
        exp_cnt = adv(1'b0, exp_cnt);
        recv_byte(1'b0, b);
        check("R7 slave silent after nack", 32'(b), 32'hFF);
        bus_stop();

        // R10: repeated start after a data byte, then current-address read
        bus_start();
        send_byte(slave_byte(1'b0, 1'b0), ack);
        send_byte(8'h00, ack);
        send_byte(8'h20, ack);
        send_byte(8'h5A, ack);
        exp_arr[9'h020] = 8'h5A;
        bus_start();
        send_byte(slave_byte(1'b0, 1'b1), ack);
        check("R10 repeated start after data byte ack", 32'(ack), 1);
        recv_byte(1'b0, b);
        check("R10 counter continues after repeated start", 32'(b), 32'(exp_arr[9'h021]));
        bus_stop();
        exp_cnt = 9'h022;
        read_random(1'b0, 9'h020, 1);

        // R4: current-address read in the register bank after array use
        read_current(1'b1, 2);

        // Random rounds
        for (int r = 0; r < 16; r++) begin
            sp  = 1'($urandom % 2);
            a   = 9'($urandom % 512);
            len = 1 + int'($urandom % 4);
            for (int i = 0; i < 8; i++) wbuf[i] = 8'($urandom);
            write_txn(sp, a, len, 7'($urandom));
            read_random(sp, a, len);
            if (($urandom % 2) == 1) read_current(1'($urandom % 2), 1 + int'($urandom % 2));
        end

        check("R11 sda_oe stable while SCL high", 32'(oe_viol), 0);
        finish_run();
    end

endmodule